// File: doc/BRIEF.md
# Auto-Baud Serial Boot Handshake

After reset this block watches an asynchronous serial receive line while a host repeatedly sends zero bytes in 8N1 format (one start bit, eight data bits, one stop bit, no parity). A zero byte holds the line low for the start bit and all eight data bits. That is nine bit times in one unbroken low stretch. The block counts the clock cycles of that stretch and divides the count by nine, rounding to the nearest integer, to get the bit period in clock cycles.

With that divisor the block runs its own 8N1 transmitter and receiver. It first sends one zero byte to tell the host that calibration is finished. It then expects a single 0x55 byte back. A correct byte puts the block into a locked state. Any other byte, or a byte whose stop bit reads low, puts it into a failed state. Either state is kept until reset. The divisor stays on its output so later logic can reuse the rate.

Host rates of 2400, 4800 and 9600 bps are supported. The lowest usable system clock rises with the rate: 2 MHz at 2400 bps, 4 MHz at 4800 bps and 8 MHz at 9600 bps.

Top module: `baud_lock_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `txd` is high, `locked` and `failed` are low and `bit_div` is zero.
- R2: A low interval on `rxd` of L clock cycles, with L between MIN_LOW and MAX_LOW inclusive, sets `bit_div` to floor((L + 4) / 9) once the line returns high.
- R3: A low interval shorter than MIN_LOW cycles is a glitch. It leaves `bit_div` unchanged and causes no transmission.
- R4: A low interval longer than MAX_LOW cycles is a break and is ignored like a glitch. The low counter stops at 2^CNT_W - 1 and does not wrap, so an interval longer than that full count is also ignored.
- R5: After a valid measurement the block sends exactly one 8N1 frame of value 0x00, least significant bit first, each bit lasting `bit_div` cycles. `txd` is therefore low for 9 x `bit_div` consecutive cycles and then high. At all other times `txd` stays high.
- R6: Once that frame has finished, the receiver samples a byte at the derived rate. It takes each bit half a bit period after the start edge, then one full period apart. If the byte is 0x55 and its stop bit is high, `locked` rises.
- R7: A received byte whose value is not 0x55, or whose stop bit is low, raises `failed` instead.
- R8: `locked` and `failed` are never high together, and each stays high until reset. After either is set, `bit_div` stays frozen and further activity on `rxd` causes no transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| bit_div | output | CNT_W-3 | Derived bit period in clock cycles |
| locked | output | 1 | Handshake completed with 0x55 |
| failed | output | 1 | Confirmation byte wrong or badly framed |

## Verification
The bench builds the block with CNT_W = 12, MIN_LOW = 36 and MAX_LOW = 3000. This makes the saturation point (4095) and the break limit reachable within a few thousand cycles. It sweeps every low length from 40 to 200 cycles. For each length it checks the rounded divisor, the exact low time of the acknowledge frame, and a full 0x55 confirmation at that rate, so every rounding boundary of the divide-by-nine is hit. Separate runs probe:
- the glitch edge at 35 and 36 cycles;
- the break edge at 3000 and 3001 cycles;
- an overlong interval that would be accepted if the counter wrapped;
- several wrong confirmation values and a low stop bit;
- line activity after lock and after failure.

// File: rtl/baud_lock_pkg.sv
// Shared definitions for the auto-baud handshake.
// Assumes 8N1 framing; constants below define the calibration and reply bytes.
package baud_lock_pkg;

    typedef enum logic [2:0] {
        HS_MEASURE,
        HS_ACK,
        HS_CONFIRM,
        HS_LOCKED,
        HS_FAILED
    } hs_state_t;

    localparam logic [7:0] ACK_BYTE     = 8'h00;
    localparam logic [7:0] CONFIRM_BYTE = 8'h55;
    localparam int         LOW_BITS     = 9;
    localparam int         FRAME_BITS   = 10;

endpackage

// File: rtl/baud_lock_meter.sv
// Synchronizes rxd and measures each low interval in clock cycles.
// A measurement is reported when the line returns high and the interval lies
// within [MIN_LOW, MAX_LOW]. The counter saturates at its full count.
// The reported divisor is the interval divided by nine, rounded to nearest.
// Assumes rxd idles high; reset values treat the line as idle.
module baud_lock_meter #(
    parameter int CNT_W   = 20,
    parameter int DIV_W   = 17,
    parameter int MIN_LOW = 64,
    parameter int MAX_LOW = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             rx_s,
    output logic             meas_valid,
    output logic [DIV_W-1:0] meas_div
);
    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LO_LIM   = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] HI_LIM   = CNT_W'(MAX_LOW);

    logic             sync_a;
    logic             rx_prev;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W:0]   rounded;
    logic             in_window;
    logic             chk_arm;

    assign rounded   = {1'b0, lo_cnt} + (CNT_W+1)'(baud_lock_pkg::LOW_BITS / 2);
    assign in_window = (lo_cnt >= LO_LIM) && (lo_cnt <= HI_LIM);

    // Two-flop synchronizer for the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a  <= 1'b1;
            rx_s    <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            sync_a  <= rxd;
            rx_s    <= sync_a;
            rx_prev <= rx_s;
        end
    end

    // Saturating count of consecutive low cycles on the synchronized line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if (rx_s) begin
            lo_cnt <= '0;
        end else if (lo_cnt != CNT_FULL) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Report a rounded divisor on each rising edge that ends a valid interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_valid <= 1'b0;
            meas_div   <= '0;
        end else begin
            meas_valid <= 1'b0;
            if (rx_s && !rx_prev && in_window) begin
                meas_valid <= 1'b1;
                meas_div   <= DIV_W'(rounded / (CNT_W+1)'(baud_lock_pkg::LOW_BITS));
            end
        end
    end

    // Arms checks one cycle after reset so that $past sees defined history.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_arm <= 1'b0;
        else        chk_arm <= 1'b1;
    end

    // R4: a counter at full count stays there while the line stays low.
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm && !rx_s && $past(!rx_s) && $past(lo_cnt) == CNT_FULL) |-> (lo_cnt == CNT_FULL));

    // R3/R4: a reported divisor never comes from outside the window.
    p_div_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (meas_div >= DIV_W'((MIN_LOW + 4) / 9) && meas_div <= DIV_W'((MAX_LOW + 4) / 9)));

endmodule

// File: rtl/baud_lock_tx.sv
// 8N1 transmitter with a run-time bit length in clock cycles.
// A start pulse while idle loads a byte; the start bit appears on the next
// cycle and the frame lasts FRAME_BITS x bit_len cycles. Assumes bit_len >= 1.
module baud_lock_tx #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] bit_len,
    output logic             txd,
    output logic             busy,
    output logic             done_p
);
    localparam int FB = baud_lock_pkg::FRAME_BITS;

    logic [FB-1:0]    shreg;
    logic [3:0]       left;
    logic [DIV_W-1:0] tcnt;

    assign txd = busy ? shreg[0] : 1'b1;

    // Loads, shifts and times one frame; pulses done_p at the end of the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            left   <= '0;
            tcnt   <= '0;
            busy   <= 1'b0;
            done_p <= 1'b0;
        end else begin
            done_p <= 1'b0;
            if (!busy) begin
                if (start) begin
                    shreg <= {1'b1, data, 1'b0};
                    left  <= 4'(FB);
                    tcnt  <= '0;
                    busy  <= 1'b1;
                end
            end else if (tcnt == bit_len - 1'b1) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FB-1:1]};
                left  <= left - 1'b1;
                if (left == 4'd1) begin
                    busy   <= 1'b0;
                    done_p <= 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R5: the first transmitted cycle of every frame is a low start bit.
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R5: completion is reported only once the line has returned to idle.
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |-> (!busy && txd));

endmodule

// File: rtl/baud_lock_rx.sv
// 8N1 receiver with a run-time bit length in clock cycles.
// While enabled and idle, a low level on the synchronized line starts a frame.
// The start bit is confirmed at half a period, data bits follow LSB first one
// period apart, and the stop bit is then checked. A start bit that reads high
// again is discarded. Assumes rx is already synchronized.
module baud_lock_rx #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx,
    input  logic [DIV_W-1:0] bit_len,
    output logic             valid,
    output logic [7:0]       data,
    output logic             ferr
);
    logic             active;
    logic [3:0]       bidx;
    logic [DIV_W-1:0] tcnt;
    logic [DIV_W-1:0] lim;

    assign lim = (bidx == 4'd0) ? (bit_len >> 1) : (bit_len - 1'b1);

    // Frame state: detects the start, times the sample points, shifts in bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bidx   <= '0;
            tcnt   <= '0;
            data   <= '0;
            valid  <= 1'b0;
            ferr   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!active) begin
                if (en && !rx) begin
                    active <= 1'b1;
                    bidx   <= '0;
                    tcnt   <= '0;
                end
            end else if (tcnt == lim) begin
                tcnt <= '0;
                bidx <= bidx + 1'b1;
                if (bidx == 4'd0) begin
                    if (rx) active <= 1'b0;
                end else if (bidx <= 4'd8) begin
                    data <= {rx, data[7:1]};
                end else begin
                    valid  <= 1'b1;
                    ferr   <= !rx;
                    active <= 1'b0;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R6: a completed byte is only reported after the stop-bit slot.
    p_valid_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !active);

endmodule

// File: rtl/baud_lock_top.sv
// Auto-baud boot handshake: measures a zero calibration byte, sends a zero
// acknowledge at the derived rate, then checks for a 0x55 confirmation.
// Assumes the host sends zero bytes until it sees the acknowledge, and then
// sends exactly one confirmation byte after the acknowledge has finished.
module baud_lock_top #(
    parameter int CNT_W   = 20,
    parameter int DIV_W   = CNT_W - 3,
    parameter int MIN_LOW = 64,
    parameter int MAX_LOW = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             txd,
    output logic [DIV_W-1:0] bit_div,
    output logic             locked,
    output logic             failed
);
    import baud_lock_pkg::*;

    hs_state_t        state;
    logic             rx_s;
    logic             meas_valid;
    logic [DIV_W-1:0] meas_div;
    logic             tx_start;
    logic             tx_busy;
    logic             tx_done;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             rx_ferr;
    logic             chk_arm;

    baud_lock_meter #(
        .CNT_W  (CNT_W),
        .DIV_W  (DIV_W),
        .MIN_LOW(MIN_LOW),
        .MAX_LOW(MAX_LOW)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .rx_s      (rx_s),
        .meas_valid(meas_valid),
        .meas_div  (meas_div)
    );

    baud_lock_tx #(.DIV_W(DIV_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tx_start),
        .data   (ACK_BYTE),
        .bit_len(bit_div),
        .txd    (txd),
        .busy   (tx_busy),
        .done_p (tx_done)
    );

    baud_lock_rx #(.DIV_W(DIV_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state == HS_CONFIRM),
        .rx     (rx_s),
        .bit_len(bit_div),
        .valid  (rx_valid),
        .data   (rx_data),
        .ferr   (rx_ferr)
    );

    assign tx_start = (state == HS_ACK) && !tx_busy && !tx_done;
    assign locked   = (state == HS_LOCKED);
    assign failed   = (state == HS_FAILED);

    // Handshake sequencer: measure, acknowledge, confirm, then hold the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HS_MEASURE;
            bit_div <= '0;
        end else begin
            case (state)
                HS_MEASURE: if (meas_valid) begin
                    bit_div <= meas_div;
                    state   <= HS_ACK;
                end
                HS_ACK:     if (tx_done) state <= HS_CONFIRM;
                HS_CONFIRM: if (rx_valid) begin
                    state <= (!rx_ferr && rx_data == CONFIRM_BYTE) ? HS_LOCKED : HS_FAILED;
                end
                default:    state <= state;
            endcase
        end
    end

    // Arms checks one cycle after reset so that $past sees defined history.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_arm <= 1'b0;
        else        chk_arm <= 1'b1;
    end

    // R8: the two result flags never coexist.
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && failed));

    // R8: once set, a result flag is held.
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm && $past(locked)) |-> locked);

    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm && $past(failed)) |-> failed);

    // R8: the divisor does not move after the handshake has ended.
    p_div_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm && $past(locked || failed)) |-> $stable(bit_div));

    // R5: the transmitter is never busy outside the acknowledge phase.
    p_tx_only_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> (state == HS_ACK));

endmodule

// File: tb/baud_lock_top_test.sv
// Self-checking bench: sweeps calibration lengths and probes window edges,
// counter saturation, bad confirmations and post-handshake inactivity.
module baud_lock_top_test;
    localparam int CNT_W   = 12;
    localparam int DIV_W   = CNT_W - 3;
    localparam int MIN_LOW = 36;
    localparam int MAX_LOW = 3000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic             txd;
    logic [DIV_W-1:0] bit_div;
    logic             locked;
    logic             failed;

    int n_checks = 0;
    int n_fail   = 0;
    int tx_low_total = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    baud_lock_top #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .bit_div(bit_div), .locked(locked), .failed(failed)
    );

    // Running count of cycles with txd low, to detect any transmission.
    always @(negedge clk) if (!txd) tx_low_total <= tx_low_total + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; rxd = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic low_pulse(input int len);
        @(negedge clk); rxd = 1'b0;
        repeat (len) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v, input int d, input logic stopv);
        @(negedge clk); rxd = 1'b0;
        repeat (d) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = v[i];
            repeat (d) @(negedge clk);
        end
        rxd = stopv;
        repeat (d) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Waits for the acknowledge frame, checks its low time, waits out its stop bit.
    task automatic expect_ack(input int d, input string tag);
        int w = 0;
        int n = 0;
        while (txd && w < 40) begin @(negedge clk); w++; end
        while (!txd && n < 20000) begin n++; @(negedge clk); end
        check(n == 9 * d, tag, n, 9 * d);
        repeat (2 * d + 2) @(negedge clk);
    endtask

    // One full handshake: calibrate with len, then answer with v and stop bit.
    task automatic handshake(input int len, input logic [7:0] v, input logic stopv);
        int d = (len + 4) / 9;
        low_pulse(len);
        expect_ack(d, "R5 ack low time");
        check(bit_div == DIV_W'(d), "R2 divisor", int'(bit_div), d);
        check(!locked && !failed, "R8 flags idle before confirm", int'({locked, failed}), 0);
        send_byte(v, d, stopv);
    endtask

    initial begin
        int snap;
        int d;
        logic [7:0] bad [5];
        bad[0] = 8'h54; bad[1] = 8'h57; bad[2] = 8'hD5; bad[3] = 8'h00; bad[4] = 8'hFF;

        // R1: state during and right after reset.
        @(negedge clk); @(negedge clk);
        check(txd && !locked && !failed && bit_div == '0, "R1 in reset",
              int'({txd, locked, failed}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd && !locked && !failed && bit_div == '0, "R1 after reset",
              int'({txd, locked, failed}), 4);

        // R2 R5 R6: sweep every calibration length, full handshake each time.
        for (int len = 40; len <= 200; len++) begin
            do_reset();
            handshake(len, 8'h55, 1'b1);
            check(locked && !failed, "R6 locked after 0x55", int'({locked, failed}), 2);
        end

        // R3: glitch just below the minimum, then the minimum itself.
        do_reset();
        snap = tx_low_total;
        low_pulse(MIN_LOW - 1);
        repeat (60) @(negedge clk);
        check(bit_div == '0, "R3 glitch divisor", int'(bit_div), 0);
        check(tx_low_total == snap, "R3 glitch no tx", tx_low_total - snap, 0);
        handshake(MIN_LOW, 8'h55, 1'b1);
        check(locked, "R3 minimum accepted", int'(locked), 1);

        // R4: break one above the maximum, then the maximum itself.
        do_reset();
        snap = tx_low_total;
        low_pulse(MAX_LOW + 1);
        repeat (60) @(negedge clk);
        check(bit_div == '0, "R4 break divisor", int'(bit_div), 0);
        check(tx_low_total == snap, "R4 break no tx", tx_low_total - snap, 0);
        handshake(MAX_LOW, 8'h55, 1'b1);
        check(locked, "R4 maximum accepted", int'(locked), 1);

        // R4: 5000 cycles would wrap to 904 without saturation.
        do_reset();
        snap = tx_low_total;
        low_pulse(5000);
        repeat (60) @(negedge clk);
        check(bit_div == '0, "R4 saturation divisor", int'(bit_div), 0);
        check(tx_low_total == snap, "R4 saturation no tx", tx_low_total - snap, 0);
        handshake(90, 8'h55, 1'b1);
        check(locked, "R4 recovers after overlong low", int'(locked), 1);

        // R8: after lock, divisor frozen and no further transmission.
        snap = tx_low_total;
        low_pulse(180);
        repeat (300) @(negedge clk);
        check(bit_div == DIV_W'(10), "R8 divisor frozen after lock", int'(bit_div), 10);
        check(tx_low_total == snap, "R8 no tx after lock", tx_low_total - snap, 0);
        check(locked && !failed, "R8 lock held", int'({locked, failed}), 2);

        // R7: wrong confirmation values.
        for (int k = 0; k < 5; k++) begin
            do_reset();
            handshake(90, bad[k], 1'b1);
            check(failed && !locked, "R7 wrong value", int'(bad[k]), 85);
        end

        // R7: correct value but stop bit low.
        do_reset();
        handshake(90, 8'h55, 1'b0);
        check(failed && !locked, "R7 framing error", int'({locked, failed}), 1);

        // R8: after failure, a good byte and a new calibration change nothing.
        snap = tx_low_total;
        d = 10;
        send_byte(8'h55, d, 1'b1);
        low_pulse(117);
        repeat (300) @(negedge clk);
        check(failed && !locked, "R8 failure held", int'({locked, failed}), 1);
        check(bit_div == DIV_W'(10), "R8 divisor frozen after failure", int'(bit_div), 10);
        check(tx_low_total == snap, "R8 no tx after failure", tx_low_total - snap, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #720000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule